// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one complete serial flash transaction each time software starts it from a small 32-bit register port. A transaction is built from up to five phases that always run in the same order: an opcode byte, an address of up to four bytes, dummy bytes, write data and read data. The configuration word gives every phase its own byte count and its own lane width: one, two or four IO lines. Up to 16 data bytes travel in each direction per transaction.

Software loads the configuration, opcode, address and write-data words. It then writes the control word with the device number and the start bit. While the transaction runs, the start bit reads back as 1. When the transaction ends, the bit clears and a ready flag is raised, which can drive an interrupt. Software can keep the chip select asserted after a transaction ends. Several transactions then form one long frame on the bus, for example an opcode sent alone followed by many bursts of payload.

The serial clock follows SPI mode 0. It idles low, the design changes its outputs on the falling edge, and it samples inputs on the rising edge. Its period is a fixed even number of system clocks. Every byte is shifted most significant bit first, and the address is sent most significant byte first.

Top module: `fxe_top`

## Requirements
- R1: After reset, all chip selects are high, the serial clock is low, all output enables are 0, the interrupt is low, and the control/status word (offset 0x0C) reads 0x00010000: release bit 16 set, everything else clear.
- R2: Writing a word with bit 0 set to offset 0x0C while idle starts a transaction. Bit 0 then reads 1 until the transaction ends and clears by itself. A start written while a transaction runs is ignored and does not restart it.
- R3: The configuration word (offset 0x08) sets the phases, which run in this order. The opcode comes from command register (0x10) bits [7:0] and is sent only when bit 10 is 1. Address bytes: count in [13:11], clamped to 4, taken from the low bytes of register 0x14. Dummy bytes: count in [23:21]. Write bytes: count in [20:16], clamped to 16. Read bytes: count in [28:24], clamped to 16. A phase with a count of 0 is skipped.
- R4: The lane width fields are command [1:0], address [3:2], write data [5:4], dummy [7:6] and read data [9:8]. Code 0 means 1 lane, code 1 means 2 lanes, and codes 2 and 3 mean 4 lanes. A 1-lane slot drives IO0. A 2-lane slot drives IO1:IO0. A 4-lane slot drives IO3:IO0. The highest lane always carries the more significant bit, and every byte goes out MSB first. The address goes out most significant byte first.
- R5: Output enables are on, for exactly the lanes in use, during the opcode, address and write phases. They are 0 during the dummy and read phases.
- R6: In a 1-lane read, each bit is sampled from IO1. A 2-lane read samples IO1:IO0 and a 4-lane read samples IO3:IO0, MSB first. Read byte k lands in the word at 0x30+4*(k/4), bits [8*(k%4)+7 : 8*(k%4)].
- R7: Write byte k is taken from the word at 0x20+4*(k/4), bits [8*(k%4)+7 : 8*(k%4)].
- R8: The serial clock stays low outside transactions. The high half and the low half of each clock period both last CLK_DIV/2 system clocks, so each lane slot takes CLK_DIV system clocks.
- R9: At start, only chip select number control[9:8] goes low, and it stays low for the whole transaction. If release bit 16 is 1 when the transaction ends, the chip select returns high. If it is 0, the chip select stays low until software writes bit 16 as 1 while idle.
- R10: Ready status (bit 24) is set when a transaction ends and is cleared by writing 1 to it. The interrupt output is ready AND the enable bit (bit 25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_DEV | Active-low chip selects |
| spi_io_out | output | 4 | IO line output values |
| spi_io_oe | output | 4 | IO line output enables |
| spi_io_in | input | 4 | IO line input values |
| irq | output | 1 | Transaction-ready interrupt |

## Verification
A bus monitor records the IO lines and enables on every rising clock edge. That record is compared slot by slot with a stream built from the configuration word, which shows whether the phase order, byte order and lane mapping are each right. The directed cases cover an opcode-only ID read, a 4-lane read with address and dummy bytes and a start request repeated mid-transfer, a 2-lane 16-byte program, out-of-range counts that must clamp, a configuration with no phases, and two transactions sharing one held chip select. Random configurations with random lane widths and data mix write and read phases in one transaction. This catches slots miscounted across phase boundaries and data from the wrong byte lane.

// File: rtl/fxe_pkg.sv
package fxe_pkg;

    localparam int REG_W     = 32;
    localparam int MAX_DATA  = 16;
    localparam int MAX_ADDR  = 4;
    localparam int DATA_WRDS = MAX_DATA / 4;
    localparam int DEV_W     = 2;

    localparam logic [7:0] OFS_CFG = 8'h08;
    localparam logic [7:0] OFS_CTL = 8'h0C;
    localparam logic [7:0] OFS_CMD = 8'h10;
    localparam logic [7:0] OFS_ADR = 8'h14;
    localparam logic [7:0] OFS_WD0 = 8'h20;
    localparam logic [7:0] OFS_RD0 = 8'h30;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADR, PH_DUM, PH_WR, PH_RD
    } phase_e;

    typedef struct packed {
        logic [4:0] rd_n;
        logic [2:0] dum_n;
        logic [4:0] wr_n;
        logic [2:0] adr_n;
        logic       cmd_on;
        logic [1:0] rd_w;
        logic [1:0] dum_w;
        logic [1:0] wr_w;
        logic [1:0] adr_w;
        logic [1:0] cmd_w;
    } xcfg_t;

    function automatic xcfg_t unpack_cfg(logic [REG_W-1:0] w);
        xcfg_t c;
        c.rd_n   = w[28:24];
        c.dum_n  = w[23:21];
        c.wr_n   = w[20:16];
        c.adr_n  = w[13:11];
        c.cmd_on = w[10];
        c.rd_w   = w[9:8];
        c.dum_w  = w[7:6];
        c.wr_w   = w[5:4];
        c.adr_w  = w[3:2];
        c.cmd_w  = w[1:0];
        return c;
    endfunction

    function automatic logic [2:0] lane_cnt(logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] width_code(phase_e p, xcfg_t c);
        case (p)
            PH_CMD:  return c.cmd_w;
            PH_ADR:  return c.adr_w;
            PH_DUM:  return c.dum_w;
            PH_WR:   return c.wr_w;
            PH_RD:   return c.rd_w;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [4:0] phase_len(phase_e p, xcfg_t c);
        case (p)
            PH_CMD:  return {4'd0, c.cmd_on};
            PH_ADR:  return (c.adr_n > 3'(MAX_ADDR)) ? 5'(MAX_ADDR) : {2'd0, c.adr_n};
            PH_DUM:  return {2'd0, c.dum_n};
            PH_WR:   return (c.wr_n > 5'(MAX_DATA)) ? 5'(MAX_DATA) : c.wr_n;
            PH_RD:   return (c.rd_n > 5'(MAX_DATA)) ? 5'(MAX_DATA) : c.rd_n;
            default: return 5'd0;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_CMD:  return PH_ADR;
            PH_ADR:  return PH_DUM;
            PH_DUM:  return PH_WR;
            PH_WR:   return PH_RD;
            default: return PH_IDLE;
        endcase
    endfunction

    // first phase at or after p that carries at least one byte
    function automatic phase_e seek(phase_e p, xcfg_t c);
        phase_e q = p;
        for (int k = 0; k < 5; k++) begin
            if (q != PH_IDLE && phase_len(q, c) == 5'd0) q = next_phase(q);
        end
        return q;
    endfunction

endpackage

// File: rtl/fxe_regs.sv
module fxe_regs
    import fxe_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [7:0]            addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic                  rd_we,
    input  logic [3:0]            rd_idx,
    input  logic [7:0]            rd_byte,
    output logic                  go,
    output logic [REG_W-1:0]      cfg_word,
    output logic [7:0]            cmd_byte,
    output logic [REG_W-1:0]      addr_word,
    output logic [8*MAX_DATA-1:0] wbytes,
    output logic [NUM_DEV-1:0]    cs_n,
    output logic                  ready,
    output logic                  irq
);

    logic [8*MAX_DATA-1:0] rbytes;
    logic [DEV_W-1:0]      dev, cs_dev;
    logic                  rel, ie, cs_act;
    logic                  ctl_wr;

    assign ctl_wr = we && addr == OFS_CTL;
    assign go     = ctl_wr && wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_word  <= '0;
            cmd_byte  <= '0;
            addr_word <= '0;
            wbytes    <= '0;
            rbytes    <= '0;
            dev       <= '0;
            cs_dev    <= '0;
            rel       <= 1'b1;
            ie        <= 1'b0;
            ready     <= 1'b0;
            cs_act    <= 1'b0;
        end else begin
            if (we && addr == OFS_CFG) cfg_word  <= wdata;
            if (we && addr == OFS_CMD) cmd_byte  <= wdata[7:0];
            if (we && addr == OFS_ADR) addr_word <= wdata;
            for (int k = 0; k < DATA_WRDS; k++) begin
                if (we && addr == OFS_WD0 + 8'(4 * k)) wbytes[32*k +: 32] <= wdata;
            end
            if (rd_we) rbytes[8*rd_idx +: 8] <= rd_byte;
            if (ctl_wr) begin
                dev <= wdata[9:8];
                rel <= wdata[16];
                ie  <= wdata[25];
            end
            if (done)                     ready <= 1'b1;
            else if (ctl_wr && wdata[24]) ready <= 1'b0;
            if (go) begin
                cs_act <= 1'b1;
                cs_dev <= wdata[9:8];
            end else if ((done || !busy) && rel) begin
                cs_act <= 1'b0;
            end
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
        assign cs_n[d] = !(cs_act && cs_dev == DEV_W'(d));
    end

    assign irq = ready && ie;

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CFG: rdata = cfg_word;
            OFS_CTL: rdata = {6'd0, ie, ready, 7'd0, rel, 6'd0, dev, 7'd0, busy};
            OFS_CMD: rdata = {24'd0, cmd_byte};
            OFS_ADR: rdata = addr_word;
            default: rdata = '0;
        endcase
        for (int k = 0; k < DATA_WRDS; k++) begin
            if (addr == OFS_WD0 + 8'(4 * k)) rdata = wbytes[32*k +: 32];
            if (addr == OFS_RD0 + 8'(4 * k)) rdata = rbytes[32*k +: 32];
        end
    end

endmodule

// File: rtl/fxe_engine.sv
module fxe_engine
    import fxe_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [REG_W-1:0]      cfg_word,
    input  logic [7:0]            cmd_byte,
    input  logic [REG_W-1:0]      addr_word,
    input  logic [8*MAX_DATA-1:0] wbytes,
    input  logic [3:0]            io_in,
    output logic                  busy,
    output logic                  done,
    output logic                  sclk,
    output logic [3:0]            io_out,
    output logic [3:0]            io_oe,
    output logic                  rd_we,
    output logic [3:0]            rd_idx,
    output logic [7:0]            rd_byte
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    phase_e           ph, nxt_ph, first_ph;
    xcfg_t            cfg_q, new_cfg;
    logic [7:0]       cmd_q, tx, rx, smp, first_byte, same_byte, next_byte;
    logic [REG_W-1:0] adr_q;
    logic [4:0]       idx;
    logic [2:0]       slot, lanes, last_slot;
    logic [CNT_W-1:0] cnt;
    logic             last_byte;

    function automatic logic [7:0] byte_of(phase_e p, logic [4:0] k, xcfg_t c,
                                           logic [7:0] op, logic [REG_W-1:0] ad,
                                           logic [8*MAX_DATA-1:0] wd);
        logic [4:0]       n;
        logic [REG_W-1:0] t;
        n = phase_len(PH_ADR, c);
        t = ad >> {n - 5'd1 - k, 3'b000};
        case (p)
            PH_CMD:  return op;
            PH_ADR:  return t[7:0];
            PH_WR:   return wd[8*k[3:0] +: 8];
            default: return 8'h00;
        endcase
    endfunction

    assign new_cfg    = unpack_cfg(cfg_word);
    assign first_ph   = seek(PH_CMD, new_cfg);
    assign first_byte = byte_of(first_ph, 5'd0, new_cfg, cmd_byte, addr_word, wbytes);
    assign nxt_ph     = seek(next_phase(ph), cfg_q);
    assign same_byte  = byte_of(ph, idx + 5'd1, cfg_q, cmd_q, adr_q, wbytes);
    assign next_byte  = byte_of(nxt_ph, 5'd0, cfg_q, cmd_q, adr_q, wbytes);
    assign last_byte  = idx == phase_len(ph, cfg_q) - 5'd1;
    assign lanes      = lane_cnt(width_code(ph, cfg_q));
    assign last_slot  = (lanes == 3'd1) ? 3'd7 : (lanes == 3'd2) ? 3'd3 : 3'd1;
    assign done       = busy && ph == PH_IDLE;

    always_comb begin
        case (lanes)
            3'd1:    begin smp = {7'd0, io_in[1]};   io_out = {3'd0, tx[7]};   io_oe = 4'b0001; end
            3'd2:    begin smp = {6'd0, io_in[1:0]}; io_out = {2'd0, tx[7:6]}; io_oe = 4'b0011; end
            default: begin smp = {4'd0, io_in};      io_out = tx[7:4];         io_oe = 4'b1111; end
        endcase
        if (!(ph == PH_CMD || ph == PH_ADR || ph == PH_WR) || !busy) begin
            io_out = 4'd0;
            io_oe  = 4'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cfg_q   <= '0;
            cmd_q   <= '0;
            adr_q   <= '0;
            tx      <= '0;
            rx      <= '0;
            idx     <= '0;
            slot    <= '0;
            cnt     <= '0;
            busy    <= 1'b0;
            sclk    <= 1'b0;
            rd_we   <= 1'b0;
            rd_idx  <= '0;
            rd_byte <= '0;
        end else begin
            rd_we <= 1'b0;
            if (!busy) begin
                if (go) begin
                    cfg_q <= new_cfg;
                    cmd_q <= cmd_byte;
                    adr_q <= addr_word;
                    ph    <= first_ph;
                    tx    <= first_byte;
                    idx   <= '0;
                    slot  <= '0;
                    cnt   <= '0;
                    busy  <= 1'b1;
                end
            end else if (ph == PH_IDLE) begin
                busy <= 1'b0;
            end else if (cnt == CNT_W'(HALF - 1)) begin
                sclk <= 1'b1;
                rx   <= (rx << lanes) | smp;
                cnt  <= cnt + 1'b1;
            end else if (cnt == CNT_W'(CLK_DIV - 1)) begin
                sclk <= 1'b0;
                cnt  <= '0;
                if (slot != last_slot) begin
                    slot <= slot + 3'd1;
                    tx   <= tx << lanes;
                end else begin
                    slot <= '0;
                    if (ph == PH_RD) begin
                        rd_we   <= 1'b1;
                        rd_idx  <= idx[3:0];
                        rd_byte <= rx;
                    end
                    if (last_byte) begin
                        ph  <= nxt_ph;
                        idx <= '0;
                        tx  <= next_byte;
                    end else begin
                        idx <= idx + 5'd1;
                        tx  <= same_byte;
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5
    oe_off_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RD || ph == PH_DUM) |-> io_oe == 4'd0);

    // R8
    sclk_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(cnt) == CNT_W'(HALF - 1));

endmodule

// File: rtl/fxe_top.sv
module fxe_top
    import fxe_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               spi_sclk,
    output logic [NUM_DEV-1:0] spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in,
    output logic               irq
);

    logic                  go, busy, done, rd_we, ready;
    logic [3:0]            rd_idx;
    logic [7:0]            rd_byte, cmd_byte;
    logic [REG_W-1:0]      cfg_word, addr_word;
    logic [8*MAX_DATA-1:0] wbytes;

    fxe_regs #(.NUM_DEV(NUM_DEV)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done     (done),
        .rd_we    (rd_we),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte),
        .go       (go),
        .cfg_word (cfg_word),
        .cmd_byte (cmd_byte),
        .addr_word(addr_word),
        .wbytes   (wbytes),
        .cs_n     (spi_cs_n),
        .ready    (ready),
        .irq      (irq)
    );

    fxe_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .cfg_word (cfg_word),
        .cmd_byte (cmd_byte),
        .addr_word(addr_word),
        .wbytes   (wbytes),
        .io_in    (spi_io_in),
        .busy     (busy),
        .done     (done),
        .sclk     (spi_sclk),
        .io_out   (spi_io_out),
        .io_oe    (spi_io_oe),
        .rd_we    (rd_we),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte)
    );

    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sclk);

    // R5
    oe_idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_io_oe == 4'd0);

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R9
    cs_held_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(&spi_cs_n));

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

    // R10
    ready_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $fell(busy));

endmodule

// File: tb/test_fxe_top.sv
module test_fxe_top;

    localparam int PERIOD = 10;
    localparam int DIV    = 4;

    logic        clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, irq;
    logic [3:0]  spi_cs_n, spi_io_out, spi_io_oe, spi_io_in;

    always #(PERIOD / 2) clk = ~clk;

    fxe_top #(.CLK_DIV(DIV), .NUM_DEV(4)) i_fxe_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(spi_io_in), .irq(irq)
    );

    int         n_chk = 0, n_bad = 0;
    logic [3:0] in_nib [512];
    logic [3:0] mon_out[512], mon_oe[512], exp_out[512], exp_oe[512];
    logic [7:0] exp_rd [16];
    int         mon_n = 0, exp_n = 0, hi_cnt = 0;
    bit         cs_bad;
    logic [3:0] cs_want = 4'hF;
    bit         ie = 1'b0;

    assign spi_io_in = in_nib[mon_n % 512];

    always @(posedge spi_sclk) begin
        if (mon_n < 512) begin
            mon_out[mon_n] = spi_io_out;
            mon_oe[mon_n]  = spi_io_oe;
        end
        if (spi_cs_n !== cs_want) cs_bad = 1'b1;
        mon_n++;
    end

    always @(posedge clk) if (spi_sclk) hi_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int lanes(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] cfg_mk(int rn, int dn, int wn, int an, bit cmd,
                                           int rw, int dw, int ww, int aw, int cw);
        return {3'd0, 5'(rn), 3'(dn), 5'(wn), 2'd0, 3'(an), cmd,
                2'(rw), 2'(dw), 2'(ww), 2'(aw), 2'(cw)};
    endfunction

    task automatic add_byte(input logic [7:0] b, input logic [1:0] wc,
                            input bit drive, input bit is_rd, input int k);
        int         l = lanes(wc);
        logic [7:0] acc = '0;
        for (int s = 0; s < 8 / l; s++) begin
            logic [3:0] o, m, nib;
            nib = in_nib[exp_n];
            if (l == 1)      begin o = {3'd0, b[7 - s]};         m = 4'b0001; acc = {acc[6:0], nib[1]}; end
            else if (l == 2) begin o = {2'd0, b[7 - 2*s -: 2]};  m = 4'b0011; acc = {acc[5:0], nib[1:0]}; end
            else             begin o = b[7 - 4*s -: 4];          m = 4'b1111; acc = {acc[3:0], nib}; end
            exp_out[exp_n] = drive ? o : 4'd0;
            exp_oe[exp_n]  = drive ? m : 4'd0;
            exp_n++;
        end
        if (is_rd) exp_rd[k] = acc;
    endtask

    // R3 R4 R7: expected slot stream in phase order
    task automatic build_exp(input logic [31:0] c, input logic [7:0] op,
                             input logic [31:0] ad, input logic [127:0] wd, output int rn);
        int an, dn, wn;
        rn = (c[28:24] > 16) ? 16 : int'(c[28:24]);
        wn = (c[20:16] > 16) ? 16 : int'(c[20:16]);
        an = (c[13:11] > 4) ? 4 : int'(c[13:11]);
        dn = int'(c[23:21]);
        exp_n = 0;
        if (c[10]) add_byte(op, c[1:0], 1'b1, 1'b0, 0);
        for (int k = 0; k < an; k++) add_byte(ad[8*(an-1-k) +: 8], c[3:2], 1'b1, 1'b0, 0);
        for (int k = 0; k < dn; k++) add_byte(8'h00, c[7:6], 1'b0, 1'b0, 0);
        for (int k = 0; k < wn; k++) add_byte(wd[8*k +: 8], c[5:4], 1'b1, 1'b0, 0);
        for (int k = 0; k < rn; k++) add_byte(8'h00, c[9:8], 1'b0, 1'b1, k);
    endtask

    function automatic logic [31:0] ctl_word(bit start, bit clr, logic [1:0] dev, bit rel);
        return {6'd0, ie, clr, 7'd0, rel, 6'd0, dev, 7'd0, start};
    endfunction

    task automatic run_txn(input logic [31:0] c, input logic [7:0] op, input logic [31:0] ad,
                           input logic [127:0] wd, input logic [1:0] dev, input bit rel,
                           input bit poke);
        logic [31:0] st;
        int          rn, guard, bad_o, bad_e, first;
        wr(8'h08, c);
        wr(8'h10, {24'd0, op});
        wr(8'h14, ad);
        for (int k = 0; k < 4; k++) wr(8'h20 + 8'(4 * k), wd[32*k +: 32]);
        for (int i = 0; i < 512; i++) in_nib[i] = 4'($urandom);
        build_exp(c, op, ad, wd, rn);
        mon_n = 0; hi_cnt = 0; cs_bad = 1'b0;
        cs_want = ~(4'b0001 << dev);
        wr(8'h0C, ctl_word(1'b1, 1'b0, dev, rel));
        rd(8'h0C, st);
        if (exp_n > 0) check(st[0] == 1'b1, "R2", "busy bit after start", {31'd0, st[0]}, 32'd1);
        if (poke) wr(8'h0C, ctl_word(1'b1, 1'b0, dev, rel));
        guard = 0;
        do begin rd(8'h0C, st); guard++; end while (st[0] && guard < 20000);
        check(guard < 20000, "R2", "busy bit clears", {31'd0, st[0]}, 32'd0);
        check(mon_n == exp_n, "R3", "slot count", 32'(mon_n), 32'(exp_n));
        bad_o = 0; bad_e = 0; first = 0;
        for (int i = 0; i < exp_n && i < 512; i++) begin
            if ((mon_out[i] & exp_oe[i]) !== exp_out[i]) begin
                if (bad_o == 0) first = i;
                bad_o++;
            end
            if (mon_oe[i] !== exp_oe[i]) bad_e++;
        end
        check(bad_o == 0, "R4", $sformatf("IO data slot %0d", first),
              32'(mon_out[first]), 32'(exp_out[first]));
        check(bad_e == 0, "R5", "output enable slots wrong", 32'(bad_e), 32'd0);
        for (int w = 0; w < 4; w++) begin
            if (rn > 4 * w) begin
                logic [31:0] got, want, msk;
                rd(8'h30 + 8'(4 * w), got);
                want = '0; msk = '0;
                for (int b = 0; b < 4; b++) begin
                    if (4 * w + b < rn) begin
                        want[8*b +: 8] = exp_rd[4*w + b];
                        msk[8*b +: 8]  = 8'hFF;
                    end
                end
                check((got & msk) == want, "R6", $sformatf("read word %0d", w), got & msk, want);
            end
        end
        check(!cs_bad, "R9", "chip select during frame", {28'd0, spi_cs_n}, {28'd0, cs_want});
        check(hi_cnt == exp_n * DIV / 2, "R8", "clock high cycles", 32'(hi_cnt), 32'(exp_n * DIV / 2));
        check(spi_sclk == 1'b0, "R8", "clock idle level", {31'd0, spi_sclk}, 32'd0);
        check(st[24] == 1'b1, "R10", "ready after finish", {31'd0, st[24]}, 32'd1);
        check(irq == ie, "R10", "interrupt level", {31'd0, irq}, {31'd0, ie});
        @(negedge clk);
        check(spi_cs_n == (rel ? 4'hF : cs_want), "R9", "chip select after finish",
              {28'd0, spi_cs_n}, {28'd0, rel ? 4'hF : cs_want});
    endtask

    initial begin
        logic [31:0]  st;
        logic [127:0] wd;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(8'h0C, st);
        check(st == 32'h0001_0000, "R1", "status after reset", st, 32'h0001_0000);
        check(spi_cs_n == 4'hF && !spi_sclk && spi_io_oe == 4'd0 && !irq, "R1", "pins after reset",
              {23'd0, irq, spi_io_oe, spi_sclk, spi_cs_n}, 32'h0000_000F);

        ie = 1'b1;
        wd = {$urandom, $urandom, $urandom, $urandom};
        run_txn(cfg_mk(3, 0, 0, 0, 1, 0, 0, 0, 0, 0), 8'h9F, 32'h0, wd, 2'd0, 1'b1, 1'b0);
        wr(8'h0C, ctl_word(1'b0, 1'b1, 2'd0, 1'b1));
        rd(8'h0C, st);
        check(st[24] == 1'b0 && !irq, "R10", "ready cleared by write-one",
              {31'd0, st[24]}, 32'd0);

        // R2: repeated start mid-transfer must not restart
        run_txn(cfg_mk(16, 2, 0, 4, 1, 2, 2, 0, 2, 0), 8'hEB, 32'h1234_5678, wd, 2'd1, 1'b1, 1'b1);
        // R7: two-lane 16-byte program
        run_txn(cfg_mk(0, 0, 16, 3, 1, 0, 0, 1, 0, 0), 8'h02, 32'h00AB_CDEF, wd, 2'd3, 1'b1, 1'b0);
        // R3: counts beyond range clamp
        run_txn(cfg_mk(31, 0, 0, 7, 1, 1, 0, 0, 1, 0), 8'h3B, 32'hFEDC_BA98, wd, 2'd2, 1'b1, 1'b0);
        // R3: no phase at all
        run_txn(32'h0, 8'h00, 32'h0, wd, 2'd0, 1'b1, 1'b0);
        // R3 R4: write then read, code 3 as four lanes
        run_txn(cfg_mk(4, 1, 5, 2, 1, 3, 1, 2, 1, 1), 8'hA5, 32'h0000_5AC3, wd, 2'd1, 1'b1, 1'b0);

        // R9: held chip select joins two transactions
        ie = 1'b0;
        run_txn(cfg_mk(0, 0, 0, 3, 1, 0, 0, 0, 0, 0), 8'h02, 32'h0001_0203, wd, 2'd2, 1'b0, 1'b0);
        run_txn(cfg_mk(0, 0, 9, 0, 0, 0, 0, 2, 0, 0), 8'h00, 32'h0, wd, 2'd2, 1'b0, 1'b0);
        wr(8'h0C, ctl_word(1'b0, 1'b1, 2'd2, 1'b1));
        @(negedge clk);
        check(spi_cs_n == 4'hF, "R9", "release by software", {28'd0, spi_cs_n}, 32'hF);

        for (int t = 0; t < 24; t++) begin
            ie = 1'($urandom);
            wd = {$urandom, $urandom, $urandom, $urandom};
            run_txn(cfg_mk($urandom % 17, $urandom % 4, $urandom % 17, $urandom % 5, 1'($urandom),
                           $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4),
                    8'($urandom), $urandom, wd, 2'($urandom), 1'b1, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule